// File: doc/BRIEF.md
# Unified Two-Way LRU Cache

This block sits between a processor and a slow backing memory. It keeps recently used words close to the processor and holds both instruction fetches and data accesses in the same lines. It makes no distinction between the two kinds of access. The processor issues one request at a time on a 32-bit port. The request carries a byte address, a write flag and write data. The block answers with a one-cycle ready pulse, and for loads it also returns the read word.

Storage is four sets of two ways. Each line holds eight 32-bit words. A load that misses brings in the whole line as eight single-word reads, then serves the load from the refilled line. The way it evicts is the invalid one, or else the least recently used one. Stores always go through to backing memory and never allocate a line. A store that hits also refreshes the cached word.

Every backing-memory access is a pulse-and-wait exchange. The block holds the address and the write flag, strobes the start signal for exactly one clock, and then waits any number of cycles for the completion flag.

Top module: `ucache_top`

## Requirements
- R1: After reset every line is invalid, so the first load to any address causes a line fill; `cpuReady` and `memGo` are low while reset is held.
- R2: A byte address splits into bits [1:0] byte offset (ignored), bits [4:2] word within the line, bits [6:5] set, and bits [31:7] tag. Addresses that share bits [31:5] share one line.
- R3: A load miss issues eight backing reads in ascending order of word address, starting at the line base (address with bits [4:0] cleared). After the eighth read the load returns the word the memory supplied for its address.
- R4: Every backing access raises `memGo` for exactly one clock. `memAddr` and `memWe` stay unchanged from that pulse until `memDone` is seen, for any latency, and no new `memGo` appears meanwhile.
- R5: A request is taken when `cpuReq` is high and the block is idle. A load hit raises `cpuReady` for one cycle, in the cycle after the request is taken, with `cpuRdata` valid. It causes no backing access.
- R6: Two lines with different tags in the same set are resident together.
- R7: A fill into a set with both ways valid evicts the least recently used way. Every hit and every fill makes the accessed way the most recently used.
- R8: A store causes exactly one backing access, with `memWe`=1, `memAddr` equal to the request address and `memWdata` equal to the store data. `cpuReady` stays low until `memDone` for that write has been seen.
- R9: A store that hits updates the cached word, so a later load returns the stored value. A store that misses allocates nothing, so a later load to that line misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cpuReq | input | 1 | Processor request, held until ready |
| cpuWe | input | 1 | 1 = store, 0 = load or fetch |
| cpuAddr | input | 32 | Byte address of the request |
| cpuWdata | input | 32 | Store data |
| cpuRdata | output | 32 | Load data, valid with cpuReady |
| cpuReady | output | 1 | One-cycle completion pulse |
| memGo | output | 1 | One-cycle start strobe to backing memory |
| memWe | output | 1 | Backing write flag, held during the access |
| memAddr | output | 32 | Backing byte address, held during the access |
| memWdata | output | 32 | Backing write data |
| memRdata | input | 32 | Backing read data, valid once memDone has been seen |
| memDone | input | 1 | Backing completion flag |

## Verification
The bench builds the block with its default parameters: 32-bit addresses and data, four sets and eight-word lines. This geometry is small enough that a short address list can fill a set, evict from it, come back to the evicted line and cross into other sets, so the least-recently-used order can be tracked by hand. The backing-memory model takes a latency chosen per access, from one cycle to several dozen. That lets the same fill and write-through paths be driven under both short and long waits while the model watches that the held address and write flag do not change.

// File: rtl/ucache_pkg.sv
package ucache_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_FILL_GO,
    ST_FILL_WAIT,
    ST_FILL_END,
    ST_WR_GO,
    ST_WR_WAIT
  } ucState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latchReq;     // capture processor request
    logic latchVictim;  // freeze the way to be refilled
    logic wordClr;      // restart fill word counter
    logic wordInc;      // advance fill word counter
    logic fillWrite;    // store returned word into the fill way
    logic fillCommit;   // set valid, tag and recency for the filled line
    logic touchHit;     // mark the hit way most recently used
    logic storeWord;    // overwrite cached word on a store hit
    logic useFillAddr;  // backing address comes from the fill counter
  } ucStrobe_t;

endpackage

// File: rtl/ucache_dp.sv
module ucache_dp
  import ucache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SETS   = 4,
  parameter int WORDS  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ucStrobe_t         strobe,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              hit,
  output logic              reqWe,
  output logic              lastWord,
  output logic [DATA_W-1:0] cpuRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              memWe
);

  localparam int WAYS   = 2;
  localparam int OFF_W  = $clog2(DATA_W / 8);
  localparam int WORD_W = $clog2(WORDS);
  localparam int SET_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - SET_W - WORD_W - OFF_W;

  logic [ADDR_W-1:0] reqAddr;
  logic [DATA_W-1:0] reqWdata;
  logic [WORD_W-1:0] wordCnt;
  logic              fillWay;

  logic [TAG_W-1:0]  reqTag;
  logic [SET_W-1:0]  reqSet;
  logic [WORD_W-1:0] reqWord;

  logic [TAG_W-1:0]  tagArr   [SETS][WAYS];
  logic [WAYS-1:0]   validArr [SETS];
  logic [SETS-1:0]   lruArr;
  logic [DATA_W-1:0] dataArr  [SETS][WAYS][WORDS];

  logic [WAYS-1:0]   hitVec;
  logic              hitWay;
  logic              victimWay;

  assign reqTag  = reqAddr[ADDR_W-1 -: TAG_W];
  assign reqSet  = reqAddr[OFF_W+WORD_W +: SET_W];
  assign reqWord = reqAddr[OFF_W +: WORD_W];

  // tag compare per way
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign hitVec[w] = validArr[reqSet][w] && (tagArr[reqSet][w] == reqTag);
  end

  assign hit    = |hitVec;
  assign hitWay = hitVec[1];

  // empty way first, then the one not most recently used
  always_comb begin
    if (!validArr[reqSet][0])      victimWay = 1'b0;
    else if (!validArr[reqSet][1]) victimWay = 1'b1;
    else                           victimWay = lruArr[reqSet];
  end

  assign lastWord = (wordCnt == WORD_W'(WORDS - 1));
  assign cpuRdata = dataArr[reqSet][hitWay][reqWord];
  assign memWdata = reqWdata;
  assign memWe    = reqWe & ~strobe.useFillAddr;
  assign memAddr  = strobe.useFillAddr ? {reqTag, reqSet, wordCnt, {OFF_W{1'b0}}} : reqAddr;

  // request, counter and bookkeeping state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqAddr  <= '0;
      reqWdata <= '0;
      reqWe    <= 1'b0;
      wordCnt  <= '0;
      fillWay  <= 1'b0;
      lruArr   <= '0;
      for (int s = 0; s < SETS; s++) validArr[s] <= '0;
    end else begin
      if (strobe.latchReq) begin
        reqAddr  <= cpuAddr;
        reqWdata <= cpuWdata;
        reqWe    <= cpuWe;
      end
      if (strobe.latchVictim) fillWay <= victimWay;
      if (strobe.wordClr)      wordCnt <= '0;
      else if (strobe.wordInc) wordCnt <= wordCnt + 1'b1;
      if (strobe.fillCommit) begin
        validArr[reqSet][fillWay] <= 1'b1;
        lruArr[reqSet]            <= ~fillWay;
      end else if (strobe.touchHit) begin
        lruArr[reqSet] <= ~hitWay;
      end
    end
  end

  // line storage, no reset needed
  always_ff @(posedge clk) begin
    if (strobe.fillCommit) tagArr[reqSet][fillWay] <= reqTag;
    if (strobe.fillWrite)  dataArr[reqSet][fillWay][wordCnt] <= memRdata;
    if (strobe.storeWord)  dataArr[reqSet][hitWay][reqWord] <= reqWdata;
  end

  // R6: a tag is never resident in both ways of a set
  a_r6_single_match: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitVec));

  // R7: after a hit touch the recency bit points away from the hit way
  a_r7_lru_away: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.touchHit && !strobe.fillCommit) |=> (lruArr[$past(reqSet)] != $past(hitWay)));

  // R3: a committed fill leaves the line valid with the requested tag
  a_r3_commit_valid: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fillCommit |=> (validArr[$past(reqSet)][$past(fillWay)]
                           && tagArr[$past(reqSet)][$past(fillWay)] == $past(reqTag)));

endmodule

// File: rtl/ucache_ctrl.sv
module ucache_ctrl
  import ucache_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cpuReq,
  input  logic      hit,
  input  logic      reqWe,
  input  logic      lastWord,
  input  logic      memDone,
  output ucStrobe_t strobe,
  output logic      memGo,
  output logic      cpuReady,
  output logic      memBusy
);

  ucState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    strobe    = '0;
    memGo     = 1'b0;
    cpuReady  = 1'b0;
    nextState = state;
    case (state)
      ST_IDLE: begin
        if (cpuReq) begin
          strobe.latchReq = 1'b1;
          nextState       = ST_LOOKUP;
        end
      end
      ST_LOOKUP: begin
        if (reqWe) begin
          nextState = ST_WR_GO;
        end else if (hit) begin
          cpuReady        = 1'b1;
          strobe.touchHit = 1'b1;
          nextState       = ST_IDLE;
        end else begin
          strobe.latchVictim = 1'b1;
          strobe.wordClr     = 1'b1;
          nextState          = ST_FILL_GO;
        end
      end
      ST_FILL_GO: begin
        strobe.useFillAddr = 1'b1;
        memGo              = 1'b1;
        nextState          = ST_FILL_WAIT;
      end
      ST_FILL_WAIT: begin
        strobe.useFillAddr = 1'b1;
        if (memDone) begin
          strobe.fillWrite = 1'b1;
          if (lastWord) begin
            nextState = ST_FILL_END;
          end else begin
            strobe.wordInc = 1'b1;
            nextState      = ST_FILL_GO;
          end
        end
      end
      ST_FILL_END: begin
        strobe.fillCommit = 1'b1;
        nextState         = ST_LOOKUP;
      end
      ST_WR_GO: begin
        memGo     = 1'b1;
        nextState = ST_WR_WAIT;
      end
      ST_WR_WAIT: begin
        if (memDone) begin
          cpuReady = 1'b1;
          if (hit) begin
            strobe.storeWord = 1'b1;
            strobe.touchHit  = 1'b1;
          end
          nextState = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign memBusy = (state == ST_FILL_WAIT) || (state == ST_WR_WAIT);

  // R4: the start strobe never lasts two cycles
  a_r4_go_single: assert property (@(posedge clk) disable iff (!rstN)
    memGo |=> !memGo);

  // R5: the completion pulse is one cycle wide
  a_r5_ready_pulse: assert property (@(posedge clk) disable iff (!rstN)
    cpuReady |=> !cpuReady);

  // R8: a store completes only in the cycle its write is acknowledged
  a_r8_store_done: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReady && reqWe) |-> memDone);

endmodule

// File: rtl/ucache_top.sv
module ucache_top
  import ucache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SETS   = 4,
  parameter int WORDS  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              cpuReady,
  output logic              memGo,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memDone
);

  ucStrobe_t strobe;
  logic      hit;
  logic      reqWe;
  logic      lastWord;
  logic      memBusy;

  ucache_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cpuReq   (cpuReq),
    .hit      (hit),
    .reqWe    (reqWe),
    .lastWord (lastWord),
    .memDone  (memDone),
    .strobe   (strobe),
    .memGo    (memGo),
    .cpuReady (cpuReady),
    .memBusy  (memBusy)
  );

  ucache_dp #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .SETS   (SETS),
    .WORDS  (WORDS)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .cpuWe    (cpuWe),
    .cpuAddr  (cpuAddr),
    .cpuWdata (cpuWdata),
    .memRdata (memRdata),
    .hit      (hit),
    .reqWe    (reqWe),
    .lastWord (lastWord),
    .cpuRdata (cpuRdata),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .memWe    (memWe)
  );

  // R4: address and write flag hold from the strobe until completion
  a_r4_addr_hold: assert property (@(posedge clk) disable iff (!rstN)
    (memGo || (memBusy && !memDone)) |=> ($stable(memAddr) && $stable(memWe)));

endmodule

// File: tb/tb_ucache_top.sv
`timescale 1ns/1ps
module tb_ucache_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic        cpuReq, cpuWe;
  logic [31:0] cpuAddr, cpuWdata, cpuRdata;
  logic        cpuReady;
  logic        memGo, memWe;
  logic [31:0] memAddr, memWdata;
  logic [31:0] memRdata;
  logic        memDone;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  ucache_top dut (
    .clk(clk), .rstN(rstN),
    .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .cpuRdata(cpuRdata), .cpuReady(cpuReady),
    .memGo(memGo), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memDone(memDone)
  );

  // ---------------- reference backing memory ----------------
  logic [31:0] wrMem [logic [31:0]];
  int          lat = 1;
  int          goCnt = 0;
  int          wrCnt = 0;
  logic [31:0] lastWrA, lastWrD;
  logic [31:0] fillLog [16];
  logic        busyM = 1'b0;
  int          cntM;
  logic [31:0] capA, capD;
  logic        capWe;

  function automatic logic [31:0] refRead(input logic [31:0] a);
    logic [31:0] wa = {a[31:2], 2'b00};
    if (wrMem.exists(wa)) return wrMem[wa];
    return wa ^ 32'h5A5A_C3C3;
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    memDone <= 1'b0;
    if (!rstN) begin
      busyM <= 1'b0;
    end else if (busyM) begin
      // R4 held signals and no second strobe during an access
      if (memGo || memAddr != capA || memWe != capWe)
        chk(1'b0, "R4", "held addr/we changed", memAddr, capA);
      if (cntM <= 1) begin
        busyM   <= 1'b0;
        memDone <= 1'b1;
        if (capWe) begin
          wrMem[{capA[31:2], 2'b00}] = capD;
          lastWrA = capA;
          lastWrD = capD;
          wrCnt++;
        end else begin
          memRdata <= refRead(capA);
        end
      end else begin
        cntM <= cntM - 1;
      end
    end else if (memGo) begin
      busyM <= 1'b1;
      capA  <= memAddr;
      capD  <= memWdata;
      capWe <= memWe;
      cntM  <= lat;
      fillLog[goCnt & 15] = memAddr;
      goCnt++;
    end
  end

  // ---------------- watchdog ----------------
  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // ---------------- one processor access ----------------
  task automatic doAccess(input logic we, input logic [31:0] addr, input logic [31:0] wd,
                          input int expGos, input int latency, input string rq);
    int goStart, wrStart, cyc;
    logic [31:0] got;
    lat     = latency;
    goStart = goCnt;
    wrStart = wrCnt;
    @(negedge clk);
    cpuReq = 1'b1; cpuWe = we; cpuAddr = addr; cpuWdata = wd;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
      if (cpuReady && busyM) chk(1'b0, "R8", "ready while access pending", 32'd1, 32'd0);
    end while (!cpuReady && cyc < 3000);
    got    = cpuRdata;
    cpuReq = 1'b0;
    chk(cpuReady == 1'b1, rq, "request completed", 32'(cpuReady), 32'd1);
    chk(goCnt - goStart == expGos, rq, "backing access count", 32'(goCnt - goStart), 32'(expGos));
    if (!we) begin
      chk(got == refRead(addr), rq, "load data", got, refRead(addr));
      if (expGos == 0)
        chk(cyc == 1, "R5", "hit latency", 32'(cyc), 32'd1);
    end else begin
      chk(wrCnt - wrStart == 1, "R8", "write count", 32'(wrCnt - wrStart), 32'd1);
      chk(lastWrA == addr, "R8", "write address", lastWrA, addr);
      chk(lastWrD == wd, "R8", "write data", lastWrD, wd);
    end
  endtask

  // ---------------- vector table ----------------
  typedef struct packed {
    logic        we;
    logic [31:0] addr;
    logic [31:0] wd;
    logic [7:0]  gos;
    logic [7:0]  lt;
    logic [7:0]  rid;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 32'h1001_0000, 32'h0,         8'd8, 8'd1, 8'd3},  // R3 cold miss
    '{1'b0, 32'h1001_0004, 32'h0,         8'd0, 8'd1, 8'd5},  // R5 hit next word
    '{1'b0, 32'h1001_0007, 32'h0,         8'd0, 8'd1, 8'd2},  // R2 byte offset ignored
    '{1'b0, 32'h1001_001C, 32'h0,         8'd0, 8'd1, 8'd2},  // R2 last word of line
    '{1'b0, 32'h1001_0020, 32'h0,         8'd8, 8'd3, 8'd2},  // R2 next line, set 1
    '{1'b0, 32'h0040_000C, 32'h0,         8'd8, 8'd2, 8'd6},  // R6 second tag, set 0
    '{1'b0, 32'h1001_0008, 32'h0,         8'd0, 8'd1, 8'd6},  // R6 both resident
    '{1'b0, 32'h0040_000C, 32'h0,         8'd0, 8'd1, 8'd7},  // R7 refresh way 1
    '{1'b0, 32'h2000_0000, 32'h0,         8'd8, 8'd5, 8'd7},  // R7 evicts 0x1001 line
    '{1'b0, 32'h0040_000C, 32'h0,         8'd0, 8'd1, 8'd7},  // R7 survivor hits
    '{1'b0, 32'h1001_0000, 32'h0,         8'd8, 8'd1, 8'd7},  // R7 evicted line refills
    '{1'b0, 32'h0040_000C, 32'h0,         8'd0, 8'd1, 8'd7},
    '{1'b0, 32'h2000_0000, 32'h0,         8'd8, 8'd4, 8'd7},  // R7 evicts 0x1001 again
    '{1'b1, 32'h0040_0010, 32'hDEAD_BEEF, 8'd1, 8'd3, 8'd9},  // R9 store hit
    '{1'b0, 32'h0040_0010, 32'h0,         8'd0, 8'd1, 8'd9},  // R9 cached word updated
    '{1'b1, 32'h3000_0040, 32'hCAFE_F00D, 8'd1, 8'd6, 8'd8},  // R8 store miss
    '{1'b0, 32'h3000_0040, 32'h0,         8'd8, 8'd2, 8'd9},  // R9 no allocate
    '{1'b0, 32'h1001_0020, 32'h0,         8'd0, 8'd1, 8'd2},  // R2 set 1 untouched
    '{1'b0, 32'h1001_0000, 32'h0,         8'd8, 8'd1, 8'd7}   // R7 still evicted
  };

  initial begin
    int base;
    rstN = 1'b0; cpuReq = 1'b0; cpuWe = 1'b0; cpuAddr = '0; cpuWdata = '0;
    memRdata = '0;
    repeat (4) @(negedge clk);
    // R1 quiet outputs in reset
    chk(cpuReady == 1'b0, "R1", "ready in reset", 32'(cpuReady), 32'd0);
    chk(memGo == 1'b0, "R1", "go in reset", 32'(memGo), 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++)
      doAccess(VEC[i].we, VEC[i].addr, VEC[i].wd, int'(VEC[i].gos), int'(VEC[i].lt),
               $sformatf("R%0d", VEC[i].rid));

    // R3 and R4: ascending fill order under a long wait
    base = goCnt;
    doAccess(1'b0, 32'h5000_0064, 32'h0, 8, 37, "R4");
    for (int k = 0; k < 8; k++)
      chk(fillLog[(base + k) & 15] == 32'h5000_0060 + 32'(4 * k), "R3", "fill word order",
          fillLog[(base + k) & 15], 32'h5000_0060 + 32'(4 * k));

    // R1: reset invalidates resident lines
    doAccess(1'b0, 32'h0040_0004, 32'h0, 0, 1, "R5");
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    doAccess(1'b0, 32'h0040_0004, 32'h0, 8, 2, "R1");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule